// File: doc/BRIEF.md
# Calendar Clock Core with Hold and Event Flags

This block keeps the seconds, minutes, hours, day, month and year bytes of a legacy-style real-time clock. Each pulse on the one-second input starts an update sequence that walks the carry chain one field per clock, from seconds up to the two-digit year. The sequence respects month lengths and a leap rule on the year. A configuration byte sets the number encoding, either packed BCD or plain binary. It also sets the hour style: twelve-hour with a PM marker, or twenty-four-hour. A hold bit in the same byte stops the clock so software can load a new time without a race.

Software sees a small indexed byte space through one write strobe, one read strobe and an address. A flag byte collects three event sources: alarm match, end of update, and a periodic tick that arrives from an external rate divider. The interrupt output is high while any flag is set whose enable bit is also set. Reading the flag byte clears it. Each alarm byte can be set to "any value", which gives an alarm once per second, once per minute or hour, or once per day.

Top module: `rtc_core`

## Requirements
- R1: With the hold bit (config bit 0) at 0, each `sec_tick` pulse advances the time once. Seconds and minutes wrap 59→0 and carry onward. The day carries into the month and the month into the year, and the year wraps 99→0. The byte indices are 0 seconds, 1 minutes, 2 hours, 3 day, 4 month and 5 year.
- R2: Writing the hold bit to 1 cancels an update already under way, so fields not yet stepped keep their values. While hold is 1, every `sec_tick` is ignored and no update-done flag is raised.
- R3: Config bit 1 selects the encoding of the time bytes: 0 means packed BCD (09 steps to 10 hex) and 1 means binary (09 steps to 0A hex).
- R4: Config bit 2 at 1 selects 24-hour counting, where hour 23 steps to 0 and carries into the day. At 0 it selects 12-hour counting with hour bit 7 as PM. In this mode 11 steps to 12 and toggles PM, 12 steps to 1, and 11 PM steps to 12 AM and carries into the day.
- R5: Months 4, 6, 9 and 11 have 30 days and February has 28. February has 29 days when the year value is divisible by 4. All other months have 31 days.
- R6: At the end of every update, flag bit 2 is set. `irq` rises when config bit 5 (update-done enable) is 1.
- R7: Alarm bytes at index 6 (seconds), 7 (minutes) and 8 (hours) are compared with the new time at the end of an update. A match sets flag bit 0, and `irq` follows config bit 3. An alarm byte with bits 7 and 6 both set matches any value.
- R8: Each `per_tick` pulse sets flag bit 1, and `irq` follows config bit 4. Flags are set even when their enable is 0, but `irq` stays low in that case.
- R9: Index 10 reads back the flags, with bit 7 equal to `irq`. A read of index 10 clears all flags, and `irq` falls.
- R10: `rst_n` clears config bits 4, 5 and 6 and all flags. Config bits 0, 1, 2, 3 and 7, the time bytes and the alarm bytes keep their values through the reset.
- R11: Config bits 6 and 7 read back as written and change neither the counting nor `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Resume-domain reset, synchronous, active low |
| sec_tick | input | 1 | One-cycle pulse once per second |
| per_tick | input | 1 | One-cycle pulse at the periodic rate |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe (clears flags when index is 10) |
| addr | input | ADDR_W | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request, active high |

## Verification
The case that is hardest to reach from the ports is a hold request that arrives while a carry is still moving up the fields. The sequence lasts only a few cycles after the tick, so a write that comes later finds the sequencer idle. The scenario loads seconds with 59 and pulses `sec_tick`. It then writes the hold bit in the very next cycle, so the seconds byte has already wrapped and the minutes step is the one that gets cancelled. The expected result is seconds at 00, minutes unchanged and no update flag.

// File: rtl/rtc_pkg.sv
// Package rtc_pkg: shared byte type, register indices, config/flag bit
// positions, update sequencer states and BCD/binary conversion helpers.
// Assumes time values below 100, so BCD fits two nibbles.
package rtc_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    // Register indices; the alarm bytes are contiguous from IDX_ASEC.
    localparam int IDX_SEC   = 0;
    localparam int IDX_MIN   = 1;
    localparam int IDX_HOUR  = 2;
    localparam int IDX_DAY   = 3;
    localparam int IDX_MON   = 4;
    localparam int IDX_YEAR  = 5;
    localparam int IDX_ASEC  = 6;
    localparam int IDX_AMIN  = 7;
    localparam int IDX_AHOUR = 8;
    localparam int IDX_CFG   = 9;
    localparam int IDX_FLAG  = 10;

    // Configuration byte bits.
    localparam int CF_HOLD = 0;
    localparam int CF_BIN  = 1;
    localparam int CF_H24  = 2;
    localparam int CF_AEN  = 3;
    localparam int CF_PEN  = 4;
    localparam int CF_UEN  = 5;
    localparam int CF_SQW  = 6;
    localparam int CF_DST  = 7;

    // Flag bits.
    localparam int FL_ALM  = 0;
    localparam int FL_PER  = 1;
    localparam int FL_UPD  = 2;
    localparam int FL_IRQ  = 7;
    localparam int N_FLAGS = 3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SEC, ST_MIN, ST_HOUR, ST_DAY, ST_MON, ST_YEAR, ST_DONE
    } upd_state_e;

    // Stored byte to plain number.
    function automatic byte_t to_num(input byte_t v, input logic bin);
        return bin ? v : (byte_t'(v[7:4]) * 8'd10) + byte_t'(v[3:0]);
    endfunction

    // Plain number to stored byte.
    function automatic byte_t from_num(input byte_t n, input logic bin);
        return bin ? n : (((n / 8'd10) << 4) | (n % 8'd10));
    endfunction

    // Last day of a month given plain month and year numbers.
    function automatic byte_t days_in(input byte_t mon, input byte_t yr,
                                      input int leap_every);
        byte_t d;
        case (mon)
            8'd2:                     d = ((int'(yr) % leap_every) == 0) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:  d = 8'd30;
            default:                  d = 8'd31;
        endcase
        return d;
    endfunction
endpackage

// File: rtl/rtc_calendar.sv
// rtc_calendar: holds the six time bytes and runs the stepped update
// sequence, one field per clock along the carry chain. Software writes
// take priority over a step of the same byte. The hold input cancels
// a sequence in progress and blocks new ones. The time bytes have no
// reset: they survive the resume-domain reset.
module rtc_calendar import rtc_pkg::*; #(
    parameter int ADDR_W     = 4,
    parameter int YEAR_TOP   = 99,
    parameter int LEAP_EVERY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              hold,
    input  logic              bin_mode,
    input  logic              h24,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  byte_t             wr_data,
    output byte_t             sec_o,
    output byte_t             min_o,
    output byte_t             hour_o,
    output byte_t             day_o,
    output byte_t             mon_o,
    output byte_t             year_o,
    output logic              upd_done
);
    localparam byte_t YEAR_LAST = byte_t'(YEAR_TOP);

    upd_state_e state_q, state_d;
    byte_t sec_q, min_q, hour_q, day_q, mon_q, year_q;
    byte_t cur, cur_n, lo, hi, gen_next;
    logic  gen_wrap;
    byte_t hr_n, hr_k, hr_enc, hr_next;
    logic  hr_pm, hr_carry;

    // Generic field step for the field chosen by the current state.
    always_comb begin
        cur = '0;
        lo  = '0;
        hi  = '0;
        case (state_q)
            ST_SEC:  begin cur = sec_q;  hi = 8'd59; end
            ST_MIN:  begin cur = min_q;  hi = 8'd59; end
            ST_DAY:  begin
                cur = day_q; lo = 8'd1;
                hi  = days_in(to_num(mon_q, bin_mode), to_num(year_q, bin_mode), LEAP_EVERY);
            end
            ST_MON:  begin cur = mon_q;  lo = 8'd1; hi = 8'd12; end
            ST_YEAR: begin cur = year_q; hi = YEAR_LAST; end
            default: ;
        endcase
        cur_n    = to_num(cur, bin_mode);
        gen_wrap = (cur_n >= hi);
        gen_next = from_num(gen_wrap ? lo : cur_n + 8'd1, bin_mode);
    end

    // Hour step for both hour styles, with the PM marker in bit 7.
    always_comb begin
        hr_n     = to_num({1'b0, hour_q[6:0]}, bin_mode);
        hr_pm    = hour_q[7];
        hr_carry = 1'b0;
        if (h24) begin
            hr_carry = (hr_n >= 8'd23);
            hr_k     = hr_carry ? 8'd0 : hr_n + 8'd1;
        end else if (hr_n >= 8'd12) begin
            hr_k = 8'd1;
        end else if (hr_n == 8'd11) begin
            hr_k     = 8'd12;
            hr_carry = hr_pm;
            hr_pm    = ~hr_pm;
        end else begin
            hr_k = hr_n + 8'd1;
        end
        hr_enc  = from_num(hr_k, bin_mode);
        hr_next = h24 ? hr_enc : {hr_pm, hr_enc[6:0]};
    end

    // Next state: walk the carry chain; hold sends the sequencer to idle.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (sec_tick) state_d = ST_SEC;
            ST_SEC:  state_d = gen_wrap ? ST_MIN  : ST_DONE;
            ST_MIN:  state_d = gen_wrap ? ST_HOUR : ST_DONE;
            ST_HOUR: state_d = hr_carry ? ST_DAY  : ST_DONE;
            ST_DAY:  state_d = gen_wrap ? ST_MON  : ST_DONE;
            ST_MON:  state_d = gen_wrap ? ST_YEAR : ST_DONE;
            ST_YEAR: state_d = ST_DONE;
            default: state_d = ST_IDLE;
        endcase
        if (hold) state_d = ST_IDLE;
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Time bytes: a software write wins, otherwise the active step applies.
    always_ff @(posedge clk) begin
        if (wr_en && wr_addr == ADDR_W'(IDX_SEC))       sec_q  <= wr_data;
        else if (state_q == ST_SEC && !hold)            sec_q  <= gen_next;
        if (wr_en && wr_addr == ADDR_W'(IDX_MIN))       min_q  <= wr_data;
        else if (state_q == ST_MIN && !hold)            min_q  <= gen_next;
        if (wr_en && wr_addr == ADDR_W'(IDX_HOUR))      hour_q <= wr_data;
        else if (state_q == ST_HOUR && !hold)           hour_q <= hr_next;
        if (wr_en && wr_addr == ADDR_W'(IDX_DAY))       day_q  <= wr_data;
        else if (state_q == ST_DAY && !hold)            day_q  <= gen_next;
        if (wr_en && wr_addr == ADDR_W'(IDX_MON))       mon_q  <= wr_data;
        else if (state_q == ST_MON && !hold)            mon_q  <= gen_next;
        if (wr_en && wr_addr == ADDR_W'(IDX_YEAR))      year_q <= wr_data;
        else if (state_q == ST_YEAR && !hold)           year_q <= gen_next;
    end

    assign upd_done = (state_q == ST_DONE) && !hold;
    assign sec_o    = sec_q;
    assign min_o    = min_q;
    assign hour_o   = hour_q;
    assign day_o    = day_q;
    assign mon_o    = mon_q;
    assign year_o   = year_q;

    // R2: with hold high and no software write, no time byte moves.
    p_hold_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q)
                              && $stable(day_q) && $stable(mon_q) && $stable(year_q)));

    // R2: hold always leaves the sequencer idle on the next cycle.
    p_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (state_q == ST_IDLE));

    // R1: the end-of-update pulse lasts exactly one cycle per sequence.
    p_done_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |=> !upd_done);
endmodule

// File: rtl/rtc_alarm.sv
// rtc_alarm: holds the alarm bytes and compares them with the current
// time. A byte with its two top bits set matches any value. Assumes the
// alarm indices are contiguous from BASE_IDX. Alarm bytes have no reset.
module rtc_alarm import rtc_pkg::*; #(
    parameter int ADDR_W   = 4,
    parameter int N_FIELDS = 3,
    parameter int BASE_IDX = IDX_ASEC
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  byte_t                          wr_data,
    input  logic [N_FIELDS-1:0][BYTE_W-1:0] now_i,
    output logic [N_FIELDS-1:0][BYTE_W-1:0] alm_o,
    output logic                           hit
);
    logic [N_FIELDS-1:0][BYTE_W-1:0] alm_q;
    logic [N_FIELDS-1:0]             field_ok;

    for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
        // Load one alarm byte from the software port.
        always_ff @(posedge clk) begin
            if (wr_en && wr_addr == ADDR_W'(BASE_IDX + i)) alm_q[i] <= wr_data;
        end
        assign field_ok[i] = (&alm_q[i][7:6]) || (alm_q[i] == now_i[i]);
    end

    assign hit   = &field_ok;
    assign alm_o = alm_q;

    // R7: an exact match on every alarm byte must be reported as a hit.
    p_exact_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_q == now_i) |-> hit);
endmodule

// File: rtl/rtc_irq_ctrl.sv
// rtc_irq_ctrl: latches the alarm, periodic and update-done flags and
// forms the interrupt request from the flags and their enables. A read
// of the flag byte clears all flags, but a set in the same cycle wins.
module rtc_irq_ctrl import rtc_pkg::*; (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_done,
    input  logic               alarm_hit,
    input  logic               per_tick,
    input  logic               rd_clr,
    input  logic               en_alm,
    input  logic               en_per,
    input  logic               en_upd,
    output logic [N_FLAGS-1:0] flags_o,
    output logic               irq_o
);
    logic [N_FLAGS-1:0] flags_q, set_v, en_v;

    // Collect this cycle's flag sources and the matching enables.
    always_comb begin
        set_v         = '0;
        set_v[FL_ALM] = upd_done && alarm_hit;
        set_v[FL_PER] = per_tick;
        set_v[FL_UPD] = upd_done;
        en_v          = '0;
        en_v[FL_ALM]  = en_alm;
        en_v[FL_PER]  = en_per;
        en_v[FL_UPD]  = en_upd;
    end

    // Flag register: reset clears, a read clears, new events set.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (rd_clr ? '0 : flags_q) | set_v;
    end

    assign irq_o   = |(flags_q & en_v);
    assign flags_o = flags_q;

    // R6: the end of an update always leaves the update flag set.
    p_upd_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |=> flags_q[FL_UPD]);

    // R9: a read with no new event leaves no flag and no request.
    p_rdclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !upd_done && !per_tick) |=> (flags_q == '0 && !irq_o));
endmodule

// File: rtl/rtc_core.sv
// rtc_core: top of the calendar clock. It holds the configuration byte,
// which has two reset domains, decodes the byte register space and
// joins the calendar, alarm and interrupt parts. Assumes one-cycle tick
// pulses that are synchronous to clk. rdata is combinational from addr.
module rtc_core import rtc_pkg::*; #(
    parameter int ADDR_W     = 4,
    parameter int YEAR_TOP   = 99,
    parameter int LEAP_EVERY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              per_tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              irq
);
    localparam int N_ALM = IDX_AHOUR - IDX_ASEC + 1;

    logic  hold_q, bin_q, h24_q, aen_q, dst_q;
    logic  pen_q, uen_q, sqw_q;
    byte_t cfg;
    byte_t t_sec, t_min, t_hour, t_day, t_mon, t_year;
    logic  upd_done, alarm_hit, rd_clr, cfg_wr;
    logic [N_FLAGS-1:0] flags;
    logic [N_ALM-1:0][BYTE_W-1:0] alm_now, alm_val;

    assign cfg_wr = wr_en && addr == ADDR_W'(IDX_CFG);
    assign rd_clr = rd_en && addr == ADDR_W'(IDX_FLAG);

    // Config bits that no reset touches.
    always_ff @(posedge clk) begin
        if (cfg_wr) begin
            hold_q <= wdata[CF_HOLD];
            bin_q  <= wdata[CF_BIN];
            h24_q  <= wdata[CF_H24];
            aen_q  <= wdata[CF_AEN];
            dst_q  <= wdata[CF_DST];
        end
    end

    // Config bits that the resume-domain reset clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pen_q <= 1'b0;
            uen_q <= 1'b0;
            sqw_q <= 1'b0;
        end else if (cfg_wr) begin
            pen_q <= wdata[CF_PEN];
            uen_q <= wdata[CF_UEN];
            sqw_q <= wdata[CF_SQW];
        end
    end

    // Assemble the config byte for readback.
    always_comb begin
        cfg          = '0;
        cfg[CF_HOLD] = hold_q;
        cfg[CF_BIN]  = bin_q;
        cfg[CF_H24]  = h24_q;
        cfg[CF_AEN]  = aen_q;
        cfg[CF_PEN]  = pen_q;
        cfg[CF_UEN]  = uen_q;
        cfg[CF_SQW]  = sqw_q;
        cfg[CF_DST]  = dst_q;
    end

    rtc_calendar #(
        .ADDR_W(ADDR_W), .YEAR_TOP(YEAR_TOP), .LEAP_EVERY(LEAP_EVERY)
    ) u_cal (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .hold(hold_q),
        .bin_mode(bin_q), .h24(h24_q), .wr_en(wr_en), .wr_addr(addr),
        .wr_data(wdata), .sec_o(t_sec), .min_o(t_min), .hour_o(t_hour),
        .day_o(t_day), .mon_o(t_mon), .year_o(t_year), .upd_done(upd_done)
    );

    assign alm_now = {t_hour, t_min, t_sec};

    rtc_alarm #(
        .ADDR_W(ADDR_W), .N_FIELDS(N_ALM), .BASE_IDX(IDX_ASEC)
    ) u_alm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(addr),
        .wr_data(wdata), .now_i(alm_now), .alm_o(alm_val), .hit(alarm_hit)
    );

    rtc_irq_ctrl u_irq (
        .clk(clk), .rst_n(rst_n), .upd_done(upd_done), .alarm_hit(alarm_hit),
        .per_tick(per_tick), .rd_clr(rd_clr), .en_alm(aen_q), .en_per(pen_q),
        .en_upd(uen_q), .flags_o(flags), .irq_o(irq)
    );

    // Read multiplexer over the byte register space.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(IDX_SEC):   rdata = t_sec;
            ADDR_W'(IDX_MIN):   rdata = t_min;
            ADDR_W'(IDX_HOUR):  rdata = t_hour;
            ADDR_W'(IDX_DAY):   rdata = t_day;
            ADDR_W'(IDX_MON):   rdata = t_mon;
            ADDR_W'(IDX_YEAR):  rdata = t_year;
            ADDR_W'(IDX_ASEC):  rdata = alm_val[0];
            ADDR_W'(IDX_AMIN):  rdata = alm_val[1];
            ADDR_W'(IDX_AHOUR): rdata = alm_val[2];
            ADDR_W'(IDX_CFG):   rdata = cfg;
            ADDR_W'(IDX_FLAG): begin
                rdata[N_FLAGS-1:0] = flags;
                rdata[FL_IRQ]      = irq;
            end
            default:            rdata = '0;
        endcase
    end

    // R10: reset leaves the resettable enables and the request cleared.
    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> (!pen_q && !uen_q && !sqw_q && !irq));
endmodule

// File: tb/sim_rtc_core.sv
// sim_rtc_core: directed scenarios for rtc_core, one task each.
module sim_rtc_core;
    localparam logic [3:0] A_SEC = 4'd0, A_MIN = 4'd1, A_HOUR = 4'd2,
                           A_DAY = 4'd3, A_MON = 4'd4, A_YEAR = 4'd5,
                           A_ASEC = 4'd6, A_AMIN = 4'd7, A_AHOUR = 4'd8,
                           A_CFG = 4'd9, A_FLAG = 4'd10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0, per_tick = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;
    int         n_chk = 0, n_err = 0;

    always #10 clk = ~clk;

    rtc_core u0 (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .per_tick(per_tick),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #2 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic one_sec();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic one_per();
        @(negedge clk); per_tick = 1'b1;
        @(negedge clk); per_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic load(input logic [7:0] h, m, s, d, mo, y);
        wr(A_HOUR, h); wr(A_MIN, m); wr(A_SEC, s);
        wr(A_DAY, d); wr(A_MON, mo); wr(A_YEAR, y);
    endtask

    task automatic expect_time(input string tag, input logic [7:0] h, m, s, d, mo, y);
        logic [7:0] v;
        rd(A_HOUR, v); chk({tag, " hour"}, v, h);
        rd(A_MIN, v);  chk({tag, " min"}, v, m);
        rd(A_SEC, v);  chk({tag, " sec"}, v, s);
        rd(A_DAY, v);  chk({tag, " day"}, v, d);
        rd(A_MON, v);  chk({tag, " mon"}, v, mo);
        rd(A_YEAR, v); chk({tag, " year"}, v, y);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        wr(A_CFG, 8'hFF);
        do_reset();
        rd(A_CFG, v);  chk("R10 cfg after reset", v, 8'h8F);
        rd(A_FLAG, v); chk("R10 flags after reset", v, 8'h00);
        chk("R10 irq after reset", {7'd0, irq}, 8'h00);
        wr(A_CFG, 8'h04);
    endtask

    task automatic t_bcd_roll();
        logic [7:0] v;
        wr(A_CFG, 8'h04);
        load(8'h23, 8'h59, 8'h59, 8'h31, 8'h12, 8'h99);
        one_sec();
        expect_time("R1 full rollover", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
        wr(A_SEC, 8'h09); one_sec();
        rd(A_SEC, v); chk("R3 bcd 09->10", v, 8'h10);
    endtask

    task automatic t_binary();
        logic [7:0] v;
        wr(A_CFG, 8'h06);
        wr(A_SEC, 8'h09); one_sec();
        rd(A_SEC, v); chk("R3 bin 09->0A", v, 8'h0A);
        load(8'h17, 8'h3B, 8'h3B, 8'h1F, 8'h0C, 8'h63);
        one_sec();
        expect_time("R3 bin rollover", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
    endtask

    task automatic t_hour12();
        logic [7:0] v;
        wr(A_CFG, 8'h00);
        load(8'h11, 8'h59, 8'h59, 8'h05, 8'h03, 8'h10);
        one_sec(); rd(A_HOUR, v); chk("R4 11AM->12PM", v, 8'h92);
        wr(A_MIN, 8'h59); wr(A_SEC, 8'h59);
        one_sec(); rd(A_HOUR, v); chk("R4 12PM->1PM", v, 8'h81);
        load(8'h91, 8'h59, 8'h59, 8'h05, 8'h03, 8'h10);
        one_sec();
        expect_time("R4 11PM->12AM", 8'h12, 8'h00, 8'h00, 8'h06, 8'h03, 8'h10);
        wr(A_CFG, 8'h02);
        load(8'h8B, 8'h3B, 8'h3B, 8'h05, 8'h03, 8'h0A);
        one_sec();
        rd(A_HOUR, v); chk("R4 bin 11PM->12AM", v, 8'h0C);
        rd(A_DAY, v);  chk("R4 bin day carry", v, 8'h06);
        wr(A_CFG, 8'h04);
        load(8'h23, 8'h59, 8'h59, 8'h05, 8'h03, 8'h10);
        one_sec(); rd(A_HOUR, v); chk("R4 24h 23->00", v, 8'h00);
    endtask

    task automatic month_case(input string tag, input logic [7:0] d, mo, y,
                              input logic [7:0] ed, emo);
        logic [7:0] v;
        load(8'h23, 8'h59, 8'h59, d, mo, y);
        one_sec();
        rd(A_DAY, v); chk({tag, " day"}, v, ed);
        rd(A_MON, v); chk({tag, " mon"}, v, emo);
    endtask

    task automatic t_months();
        wr(A_CFG, 8'h04);
        month_case("R5 leap feb 28", 8'h28, 8'h02, 8'h24, 8'h29, 8'h02);
        month_case("R5 leap feb 29", 8'h29, 8'h02, 8'h24, 8'h01, 8'h03);
        month_case("R5 plain feb 28", 8'h28, 8'h02, 8'h23, 8'h01, 8'h03);
        month_case("R5 apr 30", 8'h30, 8'h04, 8'h23, 8'h01, 8'h05);
        month_case("R5 jan 30", 8'h30, 8'h01, 8'h23, 8'h31, 8'h01);
        month_case("R5 jan 31", 8'h31, 8'h01, 8'h23, 8'h01, 8'h02);
    endtask

    task automatic t_hold();
        logic [7:0] v;
        rd(A_FLAG, v);
        wr(A_CFG, 8'h05);
        wr(A_SEC, 8'h20);
        one_sec();
        rd(A_SEC, v);  chk("R2 tick ignored in hold", v, 8'h20);
        rd(A_FLAG, v); chk("R2 no update flag in hold", v, 8'h00);
        wr(A_CFG, 8'h04);
        wr(A_SEC, 8'h59); wr(A_MIN, 8'h07);
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        addr = A_CFG; wdata = 8'h05; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        repeat (12) @(negedge clk);
        rd(A_SEC, v);  chk("R2 abort sec stepped", v, 8'h00);
        rd(A_MIN, v);  chk("R2 abort min kept", v, 8'h07);
        rd(A_FLAG, v); chk("R2 abort no flag", v, 8'h00);
        wr(A_CFG, 8'h04);
    endtask

    task automatic t_update_irq();
        logic [7:0] v;
        wr(A_CFG, 8'h24);
        rd(A_FLAG, v);
        wr(A_SEC, 8'h10);
        one_sec();
        chk("R6 irq on update", {7'd0, irq}, 8'h01);
        rd(A_FLAG, v); chk("R6 update flag", v, 8'h84);
        chk("R9 irq cleared by read", {7'd0, irq}, 8'h00);
        rd(A_FLAG, v); chk("R9 flags cleared", v, 8'h00);
        wr(A_CFG, 8'h04);
    endtask

    task automatic t_alarm();
        logic [7:0] v;
        wr(A_CFG, 8'h0C);
        wr(A_ASEC, 8'h30); wr(A_AMIN, 8'hC0); wr(A_AHOUR, 8'hC0);
        wr(A_SEC, 8'h29); wr(A_MIN, 8'h44);
        rd(A_FLAG, v);
        one_sec();
        chk("R7 irq on alarm", {7'd0, irq}, 8'h01);
        rd(A_FLAG, v); chk("R7 alarm flags", v, 8'h85);
        one_sec();
        chk("R7 no irq on mismatch", {7'd0, irq}, 8'h00);
        rd(A_FLAG, v); chk("R7 mismatch flags", v, 8'h04);
        rd(A_ASEC, v); chk("R7 alarm readback", v, 8'h30);
        wr(A_CFG, 8'h04);
    endtask

    task automatic t_periodic();
        logic [7:0] v;
        wr(A_CFG, 8'h04);
        rd(A_FLAG, v);
        one_per();
        chk("R8 no irq when disabled", {7'd0, irq}, 8'h00);
        rd(A_FLAG, v); chk("R8 flag without enable", v, 8'h02);
        wr(A_CFG, 8'h14);
        one_per();
        chk("R8 irq when enabled", {7'd0, irq}, 8'h01);
        rd(A_FLAG, v); chk("R8 flag with irq", v, 8'h82);
        wr(A_CFG, 8'h04);
    endtask

    task automatic t_spare();
        logic [7:0] v;
        wr(A_CFG, 8'hC4);
        rd(A_FLAG, v);
        wr(A_SEC, 8'h05);
        one_sec();
        rd(A_CFG, v);  chk("R11 spare readback", v, 8'hC4);
        rd(A_SEC, v);  chk("R11 counting unchanged", v, 8'h06);
        chk("R11 no irq from spare", {7'd0, irq}, 8'h00);
        rd(A_FLAG, v); chk("R11 only update flag", v, 8'h04);
        wr(A_CFG, 8'h04);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wr(A_CFG, 8'h04);
        t_reset();
        t_bcd_roll();
        t_binary();
        t_hour12();
        t_months();
        t_hold();
        t_update_irq();
        t_alarm();
        t_periodic();
        t_spare();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule